// File: doc/BRIEF.md
# Transmit Deferral Timeout Monitor

This block watches a transmitter that is waiting for the medium. Whenever the transmitter is ready to send but carrier sense shows the line busy, the block counts bit times. With the timeout check switched on, it raises an abort once that wait runs past a fixed number of bit times (24,288 by default). The abort appears as a one-cycle pulse and as a status flag that stays set.

The wait count never accumulates across attempts. A transmission start, a completed backoff, or the transmitter dropping its ready signal each returns the count to zero. When the check is switched off, the count is held at zero and no abort is ever raised, so the transmitter may wait indefinitely. Frame transmission, collision handling and backoff timing belong to neighbouring logic. This block only takes their start and completion pulses.

Top module: `defer_monitor`

## Requirements
- R1: `deferring` is high in exactly those cycles where `tx_ready` and `carrier` are both high. It is combinational and does not depend on `check_en`.
- R2: The wait count advances by one only in a cycle where `bit_tick`, `tx_ready`, `carrier` and `check_en` are all high. A tick with `carrier` low leaves the count unchanged and does not clear it.
- R3: With the check enabled, `abort_pulse` goes high in the cycle after the (LIMIT+1)-th counted tick of one uninterrupted wait. It is high for a single cycle.
- R4: `abort_flag` is set together with `abort_pulse`. It stays set, including while `tx_ready` is low, and clears on the clock edge at which `tx_ready` is first seen high after being low.
- R5: A `tx_start` pulse returns the count to zero, so the next abort again needs LIMIT+1 counted ticks.
- R6: A `backoff_done` pulse returns the count to zero, so the next abort again needs LIMIT+1 counted ticks.
- R7: A cycle with `tx_ready` low returns the count to zero.
- R8: While `check_en` is low, the count is held at zero and no abort is raised. Clearing `check_en` partway through a wait discards the partial count.
- R9: The count saturates at LIMIT and never wraps. After an abort, continued waiting produces no further `abort_pulse` until the flag has been cleared.
- R10: After reset, `abort_pulse` and `abort_flag` are low and the count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle enable, once per bit time |
| tx_ready | input | 1 | Transmitter has a frame ready to send |
| carrier | input | 1 | Carrier sense, medium busy |
| backoff_done | input | 1 | Pulse: a backoff period has finished |
| tx_start | input | 1 | Pulse: a transmission has begun |
| check_en | input | 1 | Enables the deferral timeout check |
| deferring | output | 1 | Transmitter is currently held off |
| abort_pulse | output | 1 | One-cycle abort indication |
| abort_flag | output | 1 | Sticky abort status |

## Verification
The assertions assume that LIMIT is at least one, so that a rising edge of `tx_ready` and an expiry cannot occur on the same edge. They also assume that `tx_start` and `backoff_done` are ordinary inputs that may arrive in any cycle. The checks on clearing and on the single-cycle pulse rely only on these port-level conditions.

The bench drives every input after the clock edge, and it gives each interrupting event one full cycle. The abort flag is always cleared through a low-then-high `tx_ready` sequence, so the stimulus stays inside what the assertions take for granted.

// File: rtl/defer_pkg.sv
package defer_pkg;

  // Next value of the wait count: clear wins, then saturating increment.
  function automatic int unsigned next_wait(input int unsigned cur, input bit clr,
                                            input bit inc, input int unsigned lim);
    if (clr) return 0;
    if (inc && cur < lim) return cur + 1;
    return cur;
  endfunction

  // Expiry: a counted tick arriving when the count already sits at the limit.
  function automatic bit wait_expired(input int unsigned cur, input bit clr,
                                      input bit inc, input int unsigned lim);
    return !clr && inc && (cur == lim);
  endfunction

endpackage

// File: rtl/defer_counter.sv
module defer_counter #(
  parameter int unsigned LIMIT = 24288,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          clr,
  output logic [CW-1:0] count,
  output logic          expire
);
  import defer_pkg::*;

  logic [CW-1:0] count_nx;

  always_comb begin
    count_nx = CW'(next_wait(int'(count), clr, inc, LIMIT));
    expire   = wait_expired(int'(count), clr, inc, LIMIT);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= count_nx;
  end

  // R9: the count never passes the limit
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= LIMIT);

  // R2: without an increment request the count never rises
  p_hold_no_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !clr) |=> $stable(count));

  // R7: a clear request leaves zero
  p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));
endmodule

// File: rtl/abort_latch.sv
module abort_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic ready,
  output logic pulse,
  output logic flag
);
  logic ready_q;
  logic ready_rise;
  logic fire;

  assign ready_rise = ready && !ready_q;
  assign fire       = expire && !flag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      pulse   <= 1'b0;
      flag    <= 1'b0;
    end else begin
      ready_q <= ready;
      pulse   <= fire;
      if (fire)            flag <= 1'b1;
      else if (ready_rise) flag <= 1'b0;
    end
  end

  // R3: the pulse lasts a single cycle
  p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);

  // R4: a pulse is always accompanied by the sticky flag
  p_pulse_sets_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> flag);

  // R4: the flag holds while ready stays low
  p_flag_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !ready) |=> flag);
endmodule

// File: rtl/defer_monitor.sv
module defer_monitor #(
  parameter int unsigned LIMIT = 24288
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic tx_ready,
  input  logic carrier,
  input  logic backoff_done,
  input  logic tx_start,
  input  logic check_en,
  output logic deferring,
  output logic abort_pulse,
  output logic abort_flag
);
  localparam int CW = $clog2(LIMIT + 1);

  logic          wait_inc;
  logic          wait_clr;
  logic          wait_expire;
  logic [CW-1:0] wait_count;

  assign deferring = tx_ready && carrier;
  assign wait_inc  = bit_tick && deferring && check_en;
  assign wait_clr  = !tx_ready || tx_start || backoff_done || !check_en;

  defer_counter #(.LIMIT(LIMIT)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc    (wait_inc),
    .clr    (wait_clr),
    .count  (wait_count),
    .expire (wait_expire)
  );

  abort_latch u_abort (
    .clk    (clk),
    .rst_n  (rst_n),
    .expire (wait_expire),
    .ready  (tx_ready),
    .pulse  (abort_pulse),
    .flag   (abort_flag)
  );

  // R8: a disabled check never yields an abort
  p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !check_en |=> !abort_pulse);

  // R5: transmission start empties the count
  p_start_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> (wait_count == '0));

  // R6: backoff completion empties the count
  p_backoff_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    backoff_done |=> (wait_count == '0));
endmodule

// File: tb/sim_defer_monitor.sv
module sim_defer_monitor;
  localparam int unsigned LIM = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 1'b0, tx_ready = 1'b0, carrier = 1'b0;
  logic backoff_done = 1'b0, tx_start = 1'b0, check_en = 1'b1;
  logic deferring, abort_pulse, abort_flag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  defer_monitor #(.LIMIT(LIM)) u0 (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_ready(tx_ready),
    .carrier(carrier), .backoff_done(backoff_done), .tx_start(tx_start),
    .check_en(check_en), .deferring(deferring), .abort_pulse(abort_pulse),
    .abort_flag(abort_flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // One cycle with tx_ready low: a fresh attempt, clears count and flag.
  task automatic fresh();
    bit_tick = 0; tx_ready = 0; carrier = 0; tx_start = 0; backoff_done = 0;
    step();
    tx_ready = 1;
  endtask

  // Wait with ticks every 'per' cycles until an abort; returns counted ticks.
  task automatic measure(input int per, output int ticks);
    int cyc = 0;
    ticks = 0;
    carrier = 1;
    while (ticks < 4 * LIM) begin
      bit_tick = (cyc % per) == 0;
      if (bit_tick) ticks++;
      step();
      cyc++;
      if (abort_pulse) return;
    end
    ticks = -1;
  endtask

  // Defer n ticks and count any pulses seen.
  task automatic defer_n(input int n, output int pulses);
    pulses = 0;
    carrier = 1; bit_tick = 1;
    for (int i = 0; i < n; i++) begin
      step();
      if (abort_pulse) pulses++;
    end
  endtask

  initial begin
    int t, p;
    repeat (3) step();
    chk("R10 pulse", abort_pulse, 0);
    chk("R10 flag", abort_flag, 0);
    rst_n = 1;
    step();

    // R1: all combinations of ready/carrier/enable
    for (int v = 0; v < 8; v++) begin
      tx_ready = v[0]; carrier = v[1]; check_en = v[2];
      #1;
      chk("R1 deferring", deferring, v[0] & v[1]);
    end
    check_en = 1;

    // R10: reset count is zero -> first abort needs LIM+1 ticks
    fresh();
    measure(1, t);
    chk("R10/R3 ticks to abort", t, LIM + 1);
    chk("R4 flag set", abort_flag, 1);
    step();
    chk("R3 single cycle", abort_pulse, 0);

    // R9: continued waiting gives no further pulse and no wrap
    defer_n(3 * LIM, p);
    chk("R9 no repeat pulse", p, 0);
    chk("R9 flag holds", abort_flag, 1);

    // R4: flag survives ready low, clears on rise
    tx_ready = 0; bit_tick = 0;
    step(); step();
    chk("R4 flag while ready low", abort_flag, 1);
    tx_ready = 1;
    step();
    chk("R4 flag cleared on rise", abort_flag, 0);

    // R2: sparse tick rates
    for (int per = 2; per <= 4; per++) begin
      fresh();
      measure(per, t);
      chk("R2 sparse ticks to abort", t, LIM + 1);
    end

    // R2: carrier-low ticks neither count nor clear
    fresh();
    defer_n(10, p);
    carrier = 0; bit_tick = 1;
    repeat (7) step();
    measure(1, t);
    chk("R2 carrier-low hold", t, LIM + 1 - 10);

    // R5..R8: interrupt after k ticks for every k in 0..LIM
    for (int kind = 0; kind < 4; kind++) begin
      for (int k = 0; k <= int'(LIM); k++) begin
        fresh();
        defer_n(k, p);
        chk("R3 no early abort", p, 0);
        case (kind)
          0: tx_start = 1;
          1: backoff_done = 1;
          2: tx_ready = 0;
          default: check_en = 0;
        endcase
        step();
        tx_start = 0; backoff_done = 0; tx_ready = 1; check_en = 1;
        measure(1, t);
        case (kind)
          0: chk("R5 start restarts", t, LIM + 1);
          1: chk("R6 backoff restarts", t, LIM + 1);
          2: chk("R7 ready drop restarts", t, LIM + 1);
          default: chk("R8 enable drop restarts", t, LIM + 1);
        endcase
      end
    end

    // R8: disabled check defers indefinitely
    fresh();
    check_en = 0;
    defer_n(5 * LIM, p);
    chk("R8 no abort when disabled", p, 0);
    chk("R8 flag stays clear", abort_flag, 0);
    check_en = 1;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule